// File: doc/BRIEF.md
# Frame-Aligned Serial Word Extractor

This block sits behind the capture stage of a serial converter lane. Each clock it receives one parallel chunk of the data lane and one chunk of the frame lane. Both chunks are captured the same way and at the same width. Because the converter clock and the capture logic start at unrelated moments, a chunk usually holds the tail of one sample and the head of the next. The block keeps the previous chunk next to the current one and treats the pair as one window. The frame lane marks where each sample starts, and from that mark the block works out how far to shift the window. A barrel shift then cuts one complete sample out of the window on every clock.

The frame chunk is decoded on every cycle. When the same legal rotation has been seen on a programmable number of consecutive chunks, the shift is frozen and a lock flag goes high. From then on one aligned word is produced per clock, and this continues until reset. A mode pin selects whether the serial sample is sent most significant bit first or least significant bit first. A frame chunk that is not a legal pattern raises an error pulse and never moves the frozen shift.

Top module: `fa_word_extractor`

## Requirements
- R1: While reset is high and on the first sampling after it, `locked`, `word_vld` and `frame_err` are 0 and `word_out` is 0; a reset after lock clears all four.
- R2: Bit 11 of a chunk is its earliest received bit. A legal frame chunk is one of the 12 circular rotations of six ones next to six zeros. The start of a sample is the one-bit whose earlier neighbour (the next higher index, taken circularly) is zero. The emitted word is the sample that starts in the previous chunk and ends in the current chunk. It is registered one clock after the current chunk.
- R3: With `lsb_first` = 0, the first received bit of a sample becomes bit 11 of `word_out`.
- R4: With `lsb_first` = 1, the first received bit of a sample becomes bit 0 of `word_out`, and the remaining bits follow in rising order.
- R5: `locked` rises one clock after the LOCK_CNT-th consecutive registered chunk whose frame has the same legal rotation (default 4), and not earlier.
- R6: Once `locked` is high, it and the shift stay fixed until reset. Later frame chunks, legal or not, do not change which bits form `word_out`.
- R7: An illegal frame chunk gives a one-clock `frame_err` pulse one clock after that chunk is registered. Before lock, it also restarts the consecutive count.
- R8: `word_vld` is high on every clock that follows a clock on which `locked` was high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chunk clock |
| rst | input | 1 | Synchronous active-high reset |
| lsb_first | input | 1 | 1: sample sent least significant bit first; 0: most significant bit first |
| data_chunk | input | 12 | Captured data lane chunk, bit 11 earliest |
| frame_chunk | input | 12 | Captured frame lane chunk, bit 11 earliest |
| word_out | output | 12 | Aligned sample word |
| word_vld | output | 1 | Word strobe |
| locked | output | 1 | Shift found and frozen |
| frame_err | output | 1 | Illegal frame chunk seen |

## Verification
The bench drives a new chunk at each falling edge and samples the outputs at that same falling edge, before it drives the next chunk. The expected values are worked out from when each result is due. When chunk n is being driven, the error flag and the lock flag reflect the decode of chunk n-2. The word and its strobe reflect the pair of chunks n-3 and n-2, so the expected word is sample n-3 of the generated stream. Lock is expected at exactly two clocks after the last chunk of the qualifying run, and the first strobe one clock after that. Each check therefore compares against the cycle in which the block's registers actually present the result.

// File: rtl/fa_pkg.sv
package fa_pkg;

    parameter int WORD_W = 12;
    localparam int HALF_W  = WORD_W / 2;
    localparam int SHIFT_W = $clog2(WORD_W);
    localparam int LOCK_CNT_DEFAULT = 4;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [SHIFT_W-1:0] shift_t;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } order_e;

    // previous and current chunk of the data lane, previous on top
    typedef struct packed {
        word_t prev;
        word_t cur;
    } pair_t;

    typedef struct packed {
        logic   legal;
        shift_t shift;
    } decode_t;

    // frame pattern whose sample start sits at bit s
    function automatic word_t frame_at(input int s);
        word_t p;
        p = '0;
        for (int i = 0; i < HALF_W; i++) begin
            p[SHIFT_W'((s + WORD_W - i) % WORD_W)] = 1'b1;
        end
        return p;
    endfunction

    function automatic word_t flip(input word_t w);
        word_t r;
        for (int i = 0; i < WORD_W; i++) begin
            r[i] = w[WORD_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/fa_chunk_pipe.sv
module fa_chunk_pipe
    import fa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t data_i,
    input  word_t frame_i,
    output pair_t pair_o,
    output word_t frame_o,
    output logic  cur_v_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_o  <= '0;
            frame_o <= '0;
            cur_v_o <= 1'b0;
        end else begin
            pair_o.prev <= pair_o.cur;
            pair_o.cur  <= data_i;
            frame_o     <= frame_i;
            cur_v_o     <= 1'b1;
        end
    end

    // R2
    prev_follows_chk: assert property (@(posedge clk) disable iff (rst)
        cur_v_o |=> (pair_o.prev == $past(pair_o.cur)));

endmodule

// File: rtl/fa_frame_decode.sv
module fa_frame_decode
    import fa_pkg::*;
(
    input  word_t   frame_i,
    output decode_t dec_o
);

    always_comb begin
        dec_o = '0;
        for (int j = 0; j < WORD_W; j++) begin
            if (frame_i == frame_at(j)) begin
                dec_o.legal = 1'b1;
                dec_o.shift = shift_t'(j);
            end
        end
    end

    always_comb begin
        if (dec_o.legal) begin
            // R2
            half_ones_chk: assert ($countones(frame_i) == HALF_W);
        end
    end

endmodule

// File: rtl/fa_lock_track.sv
module fa_lock_track
    import fa_pkg::*;
#(
    parameter int LOCK_CNT = LOCK_CNT_DEFAULT
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cur_v_i,
    input  decode_t dec_i,
    output logic    locked_o,
    output shift_t  shift_o,
    output logic    err_o
);

    localparam int CNT_W = $clog2(LOCK_CNT + 1);

    shift_t           cand_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        if (cnt_q != '0 && dec_i.shift == cand_q) begin
            cnt_nxt = cnt_q + 1'b1;
        end else begin
            cnt_nxt = CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q   <= '0;
            cnt_q    <= '0;
            locked_o <= 1'b0;
            shift_o  <= '0;
            err_o    <= 1'b0;
        end else begin
            err_o <= 1'b0;
            if (cur_v_i) begin
                if (!dec_i.legal) begin
                    err_o <= 1'b1;
                    if (!locked_o) begin
                        cnt_q <= '0;
                    end
                end else if (!locked_o) begin
                    cand_q <= dec_i.shift;
                    cnt_q  <= cnt_nxt;
                    if (cnt_nxt == CNT_W'(LOCK_CNT)) begin
                        locked_o <= 1'b1;
                        shift_o  <= dec_i.shift;
                    end
                end
            end
        end
    end

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> (locked_o && $stable(shift_o)));

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(cur_v_i && dec_i.legal));

    // R7
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(cur_v_i));

endmodule

// File: rtl/fa_word_cut.sv
module fa_word_cut
    import fa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pair_t  pair_i,
    input  shift_t shift_i,
    input  logic   lock_i,
    input  order_e order_i,
    output word_t  word_o,
    output logic   vld_o
);

    logic [2*WORD_W-1:0] window;
    logic [2*WORD_W-1:0] moved;
    word_t               raw;
    word_t               oriented;

    always_comb begin
        window   = pair_i;
        moved    = window >> ((SHIFT_W+1)'(shift_i) + 1'b1);
        raw      = moved[WORD_W-1:0];
        oriented = (order_i == ORDER_LSB) ? flip(raw) : raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= lock_i;
            if (lock_i) begin
                word_o <= oriented;
            end
        end
    end

    // R8
    vld_lock_chk: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> $past(lock_i));

endmodule

// File: rtl/fa_word_extractor.sv
module fa_word_extractor
    import fa_pkg::*;
#(
    parameter int LOCK_CNT = LOCK_CNT_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lsb_first,
    input  logic [WORD_W-1:0] data_chunk,
    input  logic [WORD_W-1:0] frame_chunk,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              locked,
    output logic              frame_err
);

    pair_t   pair;
    word_t   frame_q;
    logic    cur_v;
    decode_t dec;
    shift_t  shift;

    fa_chunk_pipe u_pipe (
        .clk     (clk),
        .rst     (rst),
        .data_i  (data_chunk),
        .frame_i (frame_chunk),
        .pair_o  (pair),
        .frame_o (frame_q),
        .cur_v_o (cur_v)
    );

    fa_frame_decode u_dec (
        .frame_i (frame_q),
        .dec_o   (dec)
    );

    fa_lock_track #(.LOCK_CNT(LOCK_CNT)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .cur_v_i  (cur_v),
        .dec_i    (dec),
        .locked_o (locked),
        .shift_o  (shift),
        .err_o    (frame_err)
    );

    fa_word_cut u_cut (
        .clk     (clk),
        .rst     (rst),
        .pair_i  (pair),
        .shift_i (shift),
        .lock_i  (locked),
        .order_i (order_e'(lsb_first)),
        .word_o  (word_out),
        .vld_o   (word_vld)
    );

endmodule

// File: tb/fa_word_extractor_test.sv
`timescale 1ns/1ps
module fa_word_extractor_test;

    localparam int LOCK = 4;
    localparam int NCH  = 20;
    localparam int ROWS = 7;
    // phase, lsb_first, seed, odd chunk index (99 = none), kind (0 illegal, 1 other rotation)
    localparam int TBL [ROWS][5] = '{
        '{0,  0, 1, 99, 0},
        '{5,  0, 2, 99, 0},
        '{11, 1, 3, 99, 0},
        '{7,  1, 4, 2,  0},
        '{3,  0, 5, 8,  0},
        '{9,  1, 6, 9,  1},
        '{1,  1, 7, 1,  1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lsb_first = 1'b0;
    logic [11:0] data_chunk = '0;
    logic [11:0] frame_chunk = '0;
    logic [11:0] word_out;
    logic        word_vld;
    logic        locked;
    logic        frame_err;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    fa_word_extractor #(.LOCK_CNT(LOCK)) uut (
        .clk         (clk),
        .rst         (rst),
        .lsb_first   (lsb_first),
        .data_chunk  (data_chunk),
        .frame_chunk (frame_chunk),
        .word_out    (word_out),
        .word_vld    (word_vld),
        .locked      (locked),
        .frame_err   (frame_err)
    );

    function automatic logic [11:0] sample(input int k, input int seed);
        int v;
        v = (k + 5) * (seed * 173 + 91) + seed * 7;
        return v[11:0];
    endfunction

    // chunk n of the serial lane; bit 11 is the earliest bit
    function automatic logic [11:0] lane(input int n, input int ph, input int lsb,
                                         input int seed, input bit frm);
        logic [11:0] c;
        logic [11:0] s;
        for (int i = 0; i < 12; i++) begin
            int t, u, k, r;
            t = 12 * n + 11 - i;
            u = t + 12 - ph;
            k = u / 12 - 1;
            r = u % 12;
            s = sample(k, seed);
            if (frm) c[i] = (r < 6);
            else     c[i] = (lsb != 0) ? s[r] : s[11 - r];
        end
        return c;
    endfunction

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_row(input int ph, input int lsb, input int seed,
                           input int badi, input int kind);
        int lch;
        logic [11:0] f;
        lch = LOCK - 1;
        if (badi <= LOCK - 1) lch = badi + LOCK;
        rst = 1'b1;
        lsb_first = lsb[0];
        data_chunk = '0;
        frame_chunk = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < NCH; n++) begin
            if (n > 0) @(negedge clk);
            chk($sformatf("R5 lock n=%0d", n), {11'd0, locked}, {11'd0, n >= lch + 2});
            chk($sformatf("R8 vld n=%0d", n), {11'd0, word_vld}, {11'd0, n >= lch + 3});
            chk($sformatf("R7 err n=%0d", n), {11'd0, frame_err},
                {11'd0, (kind == 0) && (n == badi + 2)});
            if (n >= lch + 3) begin
                chk($sformatf("%s R2%s word n=%0d ph=%0d", (lsb != 0) ? "R4" : "R3",
                              (badi > lch && badi != 99) ? " R6" : "", n, ph),
                    word_out, sample(n - 3, seed));
            end
            data_chunk = lane(n, ph, lsb, seed, 1'b0);
            f = lane(n, ph, lsb, seed, 1'b1);
            if (n == badi) f = (kind == 0) ? 12'hFFF : {f[10:0], f[11]};
            frame_chunk = f;
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 reset lock", {11'd0, locked}, 12'd0);
        chk("R1 reset vld", {11'd0, word_vld}, 12'd0);
        chk("R1 reset err", {11'd0, frame_err}, 12'd0);
        chk("R1 reset word", word_out, 12'd0);

        for (int r = 0; r < ROWS; r++) begin
            run_row(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4]);
        end

        // R1 reset after lock clears everything
        run_row(4, 0, 9, 99, 0);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 relock lock", {11'd0, locked}, 12'd0);
        chk("R1 relock vld", {11'd0, word_vld}, 12'd0);
        chk("R1 relock err", {11'd0, frame_err}, 12'd0);
        chk("R1 relock word", word_out, 12'd0);

        // R6 a new phase after reset locks afresh
        run_row(6, 1, 11, 99, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL R1 watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule